// File: doc/BRIEF.md
# Burst Memory Target with Access Profiling

This block answers burst traffic from a DMA engine over the AXI4 read and write channels and keeps the transferred words in an internal word-addressed memory. Each burst opens with an address handshake. The block then moves LEN+1 beats with incrementing word addresses, and it closes a read burst with the last data beat or a write burst with a single write response. It handles one burst at a time.

An access latency is applied to every beat. The block waits that number of cycles before it presents or accepts each beat. Three 64-bit profiling counters record the latency cycles charged and the bytes read and written. Software or a test environment can read these counters at any time and can zero them with a one-cycle clear pulse.

Top module: `axi_burst_responder`

## Requirements
- R1: In the cycle after the block sees a request while idle, ARREADY (for a read) or AWREADY (for a write) is high for exactly one cycle. If both requests are pending at once, the read is taken first.
- R2: A burst moves LEN+1 beats. Beat i uses word index (byte address >> 2) + i, taken modulo the memory depth. No beat is presented after the final one.
- R3: Read beat i shows the stored word on RDATA, with RRESP = 0 (OKAY) and RID = 0.
- R4: Once RVALID is high, it stays high and RDATA and RLAST stay unchanged until the cycle in which RREADY is high.
- R5: RLAST is 1 on the final read beat and 0 on every other beat.
- R6: During a write beat, WREADY stays high until WVALID arrives. WDATA is then stored at the beat's word index.
- R7: The cycle after the final write beat is accepted, BVALID rises with BRESP = 0 (OKAY) and BID = 0. BVALID stays high until BREADY.
- R8: Each beat waits exactly lat_cfg cycles, counted from the preceding address or beat handshake, before RVALID or WREADY is raised. With lat_cfg = 0 the beat appears in the next cycle.
- R9: The elapsed-cycle counter grows by lat_cfg for every beat served.
- R10: The read-byte counter grows by (LEN+1)*4 at the final read handshake. The write-byte counter grows by the same amount at the write-response handshake.
- R11: A cnt_clr pulse makes all three counters read zero in the next cycle. The clear takes precedence over any increment in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lat_cfg | input | LAT_W | Latency per beat, in cycles |
| cnt_clr | input | 1 | Clears all profiling counters |
| elapsed_cycles | output | CNT_W | Sum of the latency charged to beats |
| rd_bytes | output | CNT_W | Bytes returned by read bursts |
| wr_bytes | output | CNT_W | Bytes stored by write bursts |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| araddr | input | ADDR_W | Read start byte address |
| arlen | input | LEN_W | Read beats minus one |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rdata | output | DATA_W | Read data |
| rresp | output | 2 | Read response, always OKAY |
| rid | output | ID_W | Read ID, always 0 |
| rlast | output | 1 | Final read beat |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awaddr | input | ADDR_W | Write start byte address |
| awlen | input | LEN_W | Write beats minus one |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wdata | input | DATA_W | Write data |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bresp | output | 2 | Write response, always OKAY |
| bid | output | ID_W | Write ID, always 0 |

## Verification
The bench builds the block with a 64-word memory and a 4-bit latency field. The small memory lets a burst that starts at word 63 wrap around to word 0, so the index arithmetic is exercised at its boundary. The narrow latency field keeps each run of settings from 0 to 3 short, so beats with no wait and beats with several waits both appear in the same run.

// File: rtl/axi_burst_responder.sv
module axi_burst_responder #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int ID_W      = 4,
  parameter int LEN_W     = 8,
  parameter int MEM_WORDS = 256,
  parameter int LAT_W     = 8,
  parameter int CNT_W     = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LAT_W-1:0]  lat_cfg,
  input  logic              cnt_clr,
  output logic [CNT_W-1:0]  elapsed_cycles,
  output logic [CNT_W-1:0]  rd_bytes,
  output logic [CNT_W-1:0]  wr_bytes,
  input  logic              arvalid,
  output logic              arready,
  input  logic [ADDR_W-1:0] araddr,
  input  logic [LEN_W-1:0]  arlen,
  output logic              rvalid,
  input  logic              rready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic [ID_W-1:0]   rid,
  output logic              rlast,
  input  logic              awvalid,
  output logic              awready,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic [LEN_W-1:0]  awlen,
  input  logic              wvalid,
  output logic              wready,
  input  logic [DATA_W-1:0] wdata,
  output logic              bvalid,
  input  logic              bready,
  output logic [1:0]        bresp,
  output logic [ID_W-1:0]   bid
);
  localparam int IDX_W = $clog2(MEM_WORDS);
  localparam int SHIFT = $clog2(DATA_W / 8);

  typedef enum logic [2:0] {
    S_IDLE, S_RADR, S_RWAIT, S_RBEAT, S_WADR, S_WWAIT, S_WBEAT, S_WRSP
  } st_t;

  st_t              st;
  logic [IDX_W-1:0] base;
  logic [LEN_W-1:0] len, beat;
  logic [LAT_W-1:0] wcnt;
  logic [DATA_W-1:0] mem [MEM_WORDS];

  logic [IDX_W-1:0] idx;
  logic last, rd_go, wr_go, rd_done, wr_done, beat_start, reading;
  logic [CNT_W-1:0] burst_bytes;

  assign idx         = base + IDX_W'(beat);
  assign last        = (beat == len);
  assign rd_go       = (st == S_RBEAT) && rready;
  assign wr_go       = (st == S_WBEAT) && wvalid;
  assign rd_done     = rd_go && last;
  assign wr_done     = (st == S_WRSP) && bready;
  assign reading     = (st == S_RADR) || (st == S_RBEAT);
  assign beat_start  = (st == S_RADR) || (st == S_WADR) ||
                       (rd_go && !last) || (wr_go && !last);
  assign burst_bytes = (CNT_W'(len) + CNT_W'(1)) << SHIFT;

  assign arready = (st == S_RADR);
  assign awready = (st == S_WADR);
  assign rvalid  = (st == S_RBEAT);
  assign rdata   = rvalid ? mem[idx] : '0;
  assign rlast   = rvalid && last;
  assign rresp   = 2'b00;
  assign rid     = '0;
  assign wready  = (st == S_WBEAT);
  assign bvalid  = (st == S_WRSP);
  assign bresp   = 2'b00;
  assign bid     = '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      base <= '0;
      len  <= '0;
      beat <= '0;
      wcnt <= '0;
    end else if (beat_start) begin
      beat <= (st == S_RADR || st == S_WADR) ? '0 : beat + 1'b1;
      wcnt <= lat_cfg - LAT_W'(1);
      if (lat_cfg == '0) st <= reading ? S_RBEAT : S_WBEAT;
      else               st <= reading ? S_RWAIT : S_WWAIT;
    end else begin
      case (st)
        S_IDLE:
          if (arvalid) begin
            base <= IDX_W'(araddr >> SHIFT);
            len  <= arlen;
            st   <= S_RADR;
          end else if (awvalid) begin
            base <= IDX_W'(awaddr >> SHIFT);
            len  <= awlen;
            st   <= S_WADR;
          end
        S_RWAIT, S_WWAIT:
          if (wcnt == '0) st <= (st == S_RWAIT) ? S_RBEAT : S_WBEAT;
          else            wcnt <= wcnt - 1'b1;
        S_RBEAT: if (rd_done) st <= S_IDLE;
        S_WBEAT: if (wr_go)   st <= S_WRSP;
        S_WRSP:  if (wr_done) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go) mem[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cnt_clr) begin
      elapsed_cycles <= '0;
      rd_bytes       <= '0;
      wr_bytes       <= '0;
    end else begin
      if (beat_start) elapsed_cycles <= elapsed_cycles + CNT_W'(lat_cfg);
      if (rd_done)    rd_bytes       <= rd_bytes + burst_bytes;
      if (wr_done)    wr_bytes       <= wr_bytes + burst_bytes;
    end
  end
endmodule

// File: rtl/axi_burst_responder_chk.sv
module axi_burst_responder_chk #(
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int CNT_W  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arready,
  input logic              awready,
  input logic              rvalid,
  input logic              rready,
  input logic [DATA_W-1:0] rdata,
  input logic [1:0]        rresp,
  input logic [ID_W-1:0]   rid,
  input logic              rlast,
  input logic              wready,
  input logic              bvalid,
  input logic              bready,
  input logic [1:0]        bresp,
  input logic [ID_W-1:0]   bid,
  input logic              cnt_clr,
  input logic [CNT_W-1:0]  elapsed_cycles,
  input logic [CNT_W-1:0]  rd_bytes,
  input logic [CNT_W-1:0]  wr_bytes
);
  AST_ARREADY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    arready |=> !arready); // R1
  AST_AWREADY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    awready |=> !awready); // R1
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arready, awready, rvalid, wready, bvalid})); // R6
  AST_RD_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> (rresp == 2'b00 && rid == '0)); // R3
  AST_RVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> (rvalid && $stable(rdata) && $stable(rlast))); // R4
  AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> bvalid); // R7
  AST_WR_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> (bresp == 2'b00 && bid == '0)); // R7
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (elapsed_cycles == '0 && rd_bytes == '0 && wr_bytes == '0)); // R11
  AST_RD_BYTES_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> rd_bytes >= $past(rd_bytes)); // R10
endmodule

bind axi_burst_responder axi_burst_responder_chk #(
  .DATA_W(DATA_W), .ID_W(ID_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .arready(arready), .awready(awready),
  .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp), .rid(rid),
  .rlast(rlast), .wready(wready), .bvalid(bvalid), .bready(bready),
  .bresp(bresp), .bid(bid), .cnt_clr(cnt_clr),
  .elapsed_cycles(elapsed_cycles), .rd_bytes(rd_bytes), .wr_bytes(wr_bytes)
);

// File: tb/axi_burst_responder_test.sv
module axi_burst_responder_test;
  localparam int WORDS = 64;
  localparam int LATW  = 4;

  logic clk = 0, rst_n = 0, cnt_clr = 0;
  logic [LATW-1:0] lat_cfg = 0;
  logic [63:0] elapsed_cycles, rd_bytes, wr_bytes;
  logic arvalid = 0, rready = 0, awvalid = 0, wvalid = 0, bready = 0;
  logic [31:0] araddr = 0, awaddr = 0, wdata = 0;
  logic [7:0] arlen = 0, awlen = 0;
  logic arready, rvalid, rlast, awready, wready, bvalid;
  logic [31:0] rdata;
  logic [1:0] rresp, bresp;
  logic [3:0] rid, bid;

  axi_burst_responder #(.MEM_WORDS(WORDS), .LAT_W(LATW)) uut (
    .clk(clk), .rst_n(rst_n), .lat_cfg(lat_cfg), .cnt_clr(cnt_clr),
    .elapsed_cycles(elapsed_cycles), .rd_bytes(rd_bytes), .wr_bytes(wr_bytes),
    .arvalid(arvalid), .arready(arready), .araddr(araddr), .arlen(arlen),
    .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp), .rid(rid),
    .rlast(rlast), .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
    .awlen(awlen), .wvalid(wvalid), .wready(wready), .wdata(wdata),
    .bvalid(bvalid), .bready(bready), .bresp(bresp), .bid(bid));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] model [WORDS];
  longint exp_el = 0, exp_rd = 0, exp_wr = 0;

  task automatic chk(string req, bit ok, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_counters();
    chk("R9", elapsed_cycles == exp_el, elapsed_cycles, exp_el);
    chk("R10", rd_bytes == exp_rd, rd_bytes, exp_rd);
    chk("R10", wr_bytes == exp_wr, wr_bytes, exp_wr);
  endtask

  task automatic rd_burst(int addr, int len, bit stall);
    int n;
    logic [31:0] held;
    arvalid = 1; araddr = addr; arlen = len;
    @(negedge clk);
    chk("R1", arready && !awready, {arready, awready}, 2'b10);
    @(negedge clk);
    arvalid = 0;
    chk("R1", !arready, arready, 0);
    for (int b = 0; b <= len; b++) begin
      n = 0;
      while (!rvalid && n <= int'(lat_cfg) + 1) begin n++; @(negedge clk); end
      chk("R8", n == int'(lat_cfg), n, lat_cfg);
      chk("R3", rdata === model[(addr / 4 + b) % WORDS], rdata, model[(addr / 4 + b) % WORDS]);
      chk("R3", rresp == 0 && rid == 0, {rresp, rid}, 0);
      chk("R5", rlast == (b == len), rlast, b == len);
      if (stall) begin
        held = rdata;
        repeat (2) begin
          @(negedge clk);
          chk("R4", rvalid && rdata == held, rdata, held);
        end
      end
      rready = 1;
      @(negedge clk);
      rready = 0;
    end
    chk("R2", !rvalid, rvalid, 0);
    exp_el += longint'(lat_cfg) * (len + 1);
    exp_rd += (len + 1) * 4;
    chk_counters();
  endtask

  task automatic wr_burst(int addr, int len, bit stall);
    int n;
    awvalid = 1; awaddr = addr; awlen = len;
    @(negedge clk);
    chk("R1", awready && !arready, {awready, arready}, 2'b10);
    @(negedge clk);
    awvalid = 0;
    for (int b = 0; b <= len; b++) begin
      wdata = 32'hA500_0000 ^ (addr << 8) ^ (b * 32'h0101_0101);
      wvalid = !stall;
      n = 0;
      while (!wready && n <= int'(lat_cfg) + 1) begin n++; @(negedge clk); end
      chk("R8", n == int'(lat_cfg), n, lat_cfg);
      if (stall) begin
        repeat (2) begin
          @(negedge clk);
          chk("R6", wready, wready, 1);
        end
        wvalid = 1;
      end
      @(negedge clk);
      wvalid = 0;
      model[(addr / 4 + b) % WORDS] = wdata;
    end
    chk("R7", bvalid && bresp == 0 && bid == 0, {bvalid, bresp, bid}, 7'h40);
    @(negedge clk);
    chk("R7", bvalid, bvalid, 1);
    bready = 1;
    @(negedge clk);
    bready = 0;
    chk("R7", !bvalid, bvalid, 0);
    exp_el += longint'(lat_cfg) * (len + 1);
    exp_wr += (len + 1) * 4;
    chk_counters();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", !arready && !awready && !rvalid && !wready && !bvalid, 0, 0);
    chk_counters();

    lat_cfg = 0;
    wr_burst(32'h40, 3, 0);
    rd_burst(32'h40, 3, 1);

    lat_cfg = 3;
    wr_burst(32'h100, 0, 0);
    rd_burst(32'h100, 0, 0);

    lat_cfg = 2;
    awvalid = 1; awaddr = 32'h80; awlen = 2;
    rd_burst(32'h44, 1, 0);
    wr_burst(32'h80, 2, 1);
    rd_burst(32'h80, 2, 0);

    lat_cfg = 1;
    wr_burst(32'hFC, 2, 0);
    rd_burst(32'hFC, 2, 1);
    chk("R2", model[0] != 0, model[0], 1);

    cnt_clr = 1;
    @(negedge clk);
    cnt_clr = 0;
    exp_el = 0; exp_rd = 0; exp_wr = 0;
    chk("R11", elapsed_cycles == 0 && rd_bytes == 0 && wr_bytes == 0, rd_bytes, 0);

    lat_cfg = 0;
    rd_burst(32'h0, 1, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule